// File: doc/BRIEF.md
# Consecutive-Fault Threshold Alarm Counter

This block watches one channel of a scanning data-acquisition system. Each conversion scan presents a strobe, the channel's current 10-bit value, an upper and a lower threshold, and the channel's 8-bit configuration byte. The block classifies the value as above the window, below the window, or inside it. It tracks how many scans in a row have faulted against the same threshold.

The upper nibble of the configuration byte holds a programmed count N. When the run of same-side faults reaches N+1, the block latches an alarm bit for that side and raises an interrupt request. A scan back inside the window empties the run. A fault on the other side starts a fresh run of one. The alarm bits stay set until a clear pulse arrives. The run counter stops at its top value instead of wrapping.

Top module: `fault_streak_monitor`

## Requirements
- R1: After reset, `alarm_hi`, `alarm_lo` and `irq` are 0 and the fault run is empty. The all-zero configuration byte means the alarm is raised on the first fault.
- R2: A high fault is `sample > limit_hi` and a low fault is `sample < limit_lo`, with unsigned comparison. A value equal to either threshold is in range. If both conditions hold, the scan counts as a high fault.
- R3: N is the fault-count field in bits 7:4 of `chan_cfg`, read as an unsigned number from 0 to 15. On a strobed scan whose fault makes the run of same-side faults reach at least N+1, the alarm bit for that side is 1 from the next rising clock edge. With N=0, the first fault raises the alarm.
- R4: A strobed scan that is in range empties the run, so a later fault counts from 1.
- R5: A fault on the side opposite to the previous fault restarts the run at 1 for the new side, not at 0.
- R6: In a cycle where `scan_valid` is 0, `sample`, the thresholds and `chan_cfg` have no effect: the alarms hold and the run is unchanged.
- R7: Alarm bits stay latched until `clear_alarm` is 1 at a clock edge. That edge clears both bits, except a bit set by a strobed scan in the same cycle, which stays 1.
- R8: The run counter saturates at 16 and does not wrap. Further same-side faults after a clear raise the alarm again on the first such scan.
- R9: `irq` is 1 exactly when at least one alarm bit is 1.
- R10: Bits 3:0 of `chan_cfg` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_valid | input | 1 | One-cycle strobe marking a completed scan of this channel |
| sample | input | 10 | Current data value of the channel |
| limit_hi | input | 10 | Upper threshold |
| limit_lo | input | 10 | Lower threshold |
| chan_cfg | input | 8 | Channel configuration byte; bits 7:4 hold the fault count N |
| clear_alarm | input | 1 | Clears the latched alarm bits |
| alarm_hi | output | 1 | Latched high-side alarm |
| alarm_lo | output | 1 | Latched low-side alarm |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume two things about the inputs. `scan_valid` and `clear_alarm` are single-cycle qualifiers, sampled only at rising edges. The data and threshold inputs are steady around each edge. The bench meets this by changing every input on the falling edge and holding it for a full cycle.

Random traffic mixes idle cycles, strobes and occasional clears. The thresholds sit close to the middle of the range, so that high, low and in-range scans all occur often. Occasionally the lower threshold is drawn above the upper one, which exercises the rule that high wins when both conditions hold.

// File: rtl/fault_streak_monitor.sv
module fault_streak_monitor #(
  parameter int DATA_W = 10,
  parameter int CFG_W  = 8,
  parameter int NFLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_valid,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] limit_hi,
  input  logic [DATA_W-1:0] limit_lo,
  input  logic [CFG_W-1:0]  chan_cfg,
  input  logic              clear_alarm,
  output logic              alarm_hi,
  output logic              alarm_lo,
  output logic              irq
);
  localparam int RUN_W   = NFLD_W + 1;
  localparam int RUN_MAX = 1 << NFLD_W;

  logic [NFLD_W-1:0] nfield;
  logic [RUN_W-1:0]  run_q, run_d, need;
  logic              side_hi_q, side_valid_q;
  logic              hi_flt, lo_flt, any_flt, same_side, hit;
  logic              unused_cfg;

  assign nfield     = chan_cfg[CFG_W-1 -: NFLD_W];
  assign unused_cfg = ^chan_cfg[CFG_W-NFLD_W-1:0];
  assign need       = {1'b0, nfield} + RUN_W'(1);

  assign hi_flt    = sample > limit_hi;
  assign lo_flt    = !hi_flt && (sample < limit_lo);
  assign any_flt   = hi_flt || lo_flt;
  assign same_side = side_valid_q && (side_hi_q == hi_flt);

  always_comb begin
    if (!any_flt)
      run_d = '0;
    else if (!same_side)
      run_d = RUN_W'(1);
    else if (run_q == RUN_W'(RUN_MAX))
      run_d = run_q;
    else
      run_d = run_q + RUN_W'(1);
  end

  assign hit = scan_valid && any_flt && (run_d >= need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q        <= '0;
      side_hi_q    <= 1'b0;
      side_valid_q <= 1'b0;
      alarm_hi     <= 1'b0;
      alarm_lo     <= 1'b0;
    end else begin
      if (scan_valid) begin
        run_q        <= run_d;
        side_hi_q    <= hi_flt;
        side_valid_q <= any_flt;
      end
      alarm_hi <= (hit && hi_flt) || (alarm_hi && !clear_alarm);
      alarm_lo <= (hit && lo_flt) || (alarm_lo && !clear_alarm);
    end
  end

  assign irq = alarm_hi || alarm_lo;
endmodule

module fault_streak_monitor_chk #(
  parameter int DATA_W = 10,
  parameter int NFLD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_valid,
  input logic [DATA_W-1:0] sample,
  input logic [DATA_W-1:0] limit_hi,
  input logic [DATA_W-1:0] limit_lo,
  input logic [NFLD_W-1:0] nfield,
  input logic              clear_alarm,
  input logic              alarm_hi,
  input logic              alarm_lo,
  input logic              irq
);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_valid && !clear_alarm) |=> ($stable(alarm_hi) && $stable(alarm_lo)));

  // R7
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_alarm && !scan_valid) |=> (!alarm_hi && !alarm_lo));

  // R2
  hi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_hi) |-> ($past(scan_valid) && $past(sample > limit_hi)));

  // R3
  first_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && sample > limit_hi && nfield == '0) |=> alarm_hi);

  // R4
  in_range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && sample <= limit_hi && sample >= limit_lo && !irq) |=> !irq);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(scan_valid));
endmodule

bind fault_streak_monitor fault_streak_monitor_chk #(.DATA_W(DATA_W), .NFLD_W(NFLD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_valid(scan_valid), .sample(sample),
  .limit_hi(limit_hi), .limit_lo(limit_lo), .nfield(chan_cfg[CFG_W-1 -: NFLD_W]),
  .clear_alarm(clear_alarm), .alarm_hi(alarm_hi), .alarm_lo(alarm_lo), .irq(irq)
);

// File: tb/sim_fault_streak_monitor.sv
`timescale 1ns/1ps
module sim_fault_streak_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_valid = 1'b0;
  logic [9:0] sample = '0, limit_hi = 10'd600, limit_lo = 10'd400;
  logic [7:0] chan_cfg = '0;
  logic       clear_alarm = 1'b0;
  logic       alarm_hi, alarm_lo, irq;

  int checks = 0, errors = 0;
  int m_run = 0, m_side = 0;
  bit m_hi = 0, m_lo = 0;

  always #2.5 clk = ~clk;

  fault_streak_monitor u0 (
    .clk(clk), .rst_n(rst_n), .scan_valid(scan_valid), .sample(sample),
    .limit_hi(limit_hi), .limit_lo(limit_lo), .chan_cfg(chan_cfg),
    .clear_alarm(clear_alarm), .alarm_hi(alarm_hi), .alarm_lo(alarm_lo), .irq(irq)
  );

  function automatic int classify(logic [9:0] s, logic [9:0] h, logic [9:0] l);
    if (s > h) return 1;
    if (s < l) return 2;
    return 0;
  endfunction

  task automatic check(string req, logic got, logic exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  task automatic step(bit sv, logic [9:0] s, logic [9:0] h, logic [9:0] l,
                      logic [7:0] cfg, bit clr, string req);
    int f, n;
    bit hit;
    @(negedge clk);
    scan_valid = sv; sample = s; limit_hi = h; limit_lo = l;
    chan_cfg = cfg; clear_alarm = clr;
    hit = 0;
    f = classify(s, h, l);
    n = int'(cfg[7:4]);
    if (sv) begin
      if (f == 0) begin m_run = 0; m_side = 0; end
      else if (f == m_side) m_run = (m_run < 16) ? m_run + 1 : 16;
      else begin m_run = 1; m_side = f; end
      hit = (f != 0) && (m_run >= n + 1);
    end
    m_hi = (hit && f == 1) || (m_hi && !clr);
    m_lo = (hit && f == 2) || (m_lo && !clr);
    @(posedge clk);
    #1;
    check(req, alarm_hi, m_hi, "alarm_hi");
    check(req, alarm_lo, m_lo, "alarm_lo");
    check("R9", irq, m_hi | m_lo, "irq");
  endtask

  task automatic scan(logic [9:0] s, logic [7:0] cfg, string req);
    step(1, s, 10'd600, 10'd400, cfg, 0, req);
  endtask

  task automatic clr(string req);
    step(0, 10'd500, 10'd600, 10'd400, 8'h00, 1, req);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h1153;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", alarm_hi, 0, "alarm_hi"); check("R1", alarm_lo, 0, "alarm_lo");
    check("R1", irq, 0, "irq");
    // R3 N=0 alarms on first fault
    scan(10'd601, 8'h00, "R3");
    clr("R7");
    // R2 equality is in range, on both thresholds
    scan(10'd600, 8'h00, "R2");
    scan(10'd400, 8'h00, "R2");
    scan(10'd399, 8'h00, "R2");
    clr("R7");
    // R3 N=2 needs three in a row
    scan(10'd700, 8'h20, "R3"); scan(10'd700, 8'h20, "R3"); scan(10'd700, 8'h20, "R3");
    clr("R7");
    // R4 in-range scan empties the run
    scan(10'd700, 8'h20, "R4"); scan(10'd700, 8'h20, "R4");
    scan(10'd500, 8'h20, "R4");
    scan(10'd700, 8'h20, "R4"); scan(10'd700, 8'h20, "R4");
    // R5 opposite side restarts at 1
    scan(10'd10, 8'h10, "R5");
    scan(10'd10, 8'h10, "R5");
    clr("R7");
    // R6 no strobe: fault values ignored
    step(0, 10'd900, 10'd600, 10'd400, 8'h00, 0, "R6");
    step(0, 10'd5, 10'd600, 10'd400, 8'h00, 0, "R6");
    // R7 set wins over clear in the same cycle
    step(1, 10'd900, 10'd600, 10'd400, 8'h00, 1, "R7");
    clr("R7");
    // R8 saturation with N=15
    for (int i = 0; i < 20; i++) scan(10'd800, 8'hF0, "R8");
    clr("R8");
    scan(10'd800, 8'hF0, "R8");
    clr("R8");
    // R10 low config bits ignored
    scan(10'd500, 8'h0F, "R10");
    scan(10'd800, 8'h1F, "R10");
    scan(10'd800, 8'h1F, "R10");
    clr("R10");
    // R2 high wins when both conditions hold
    step(1, 10'd500, 10'd450, 10'd550, 8'h00, 0, "R2");
    clr("R2");
    // random traffic, checked against the model (R3)
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] s, h, l;
      h = 10'(500 + ($urandom % 40));
      l = ($urandom % 20 == 0) ? 10'(h + 5) : 10'(h - 60 - ($urandom % 40));
      s = 10'(h - 120 + ($urandom % 200));
      step(($urandom % 10) < 7, s, h, l, 8'($urandom), ($urandom % 20) == 0, "R3");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule